// File: doc/BRIEF.md
# CAN bit timing generator

This block divides a system clock into CAN time quanta and walks each bit through its three phases: a one-quantum synchronization segment, time segment 1 and time segment 2. A programmable prescaler sets how many clock cycles make up one quantum. A segment counter steps through the quanta of the bit. Three one-clock strobes come out: one at the start of each quantum, one at the sample point, and one at the start of each bit. A protocol engine uses them to place bit sampling and bit transmission.

Segment lengths are given as compact codes. A code of n selects n+1 quanta, so the 4-bit segment-1 code covers 1 to 16 quanta and the 3-bit segment-2 code covers 1 to 8. Segment-1 codes below 3 give a segment too short for a usable sample point. Such a code raises a configuration-error flag, and the block still runs with the lengths it was given. The configuration is captured only at bit boundaries, or at any time while the block is disabled. Changes made in the middle of a bit therefore never disturb the bit in progress.

Top module: `can_bit_timer`

## Requirements
- R1: While `rst` is high, and after it is released with `enable` low, `tq_tick`, `sample_pulse`, `bit_start` and `cfg_err` (for a segment-1 code of 3 or more) are all low.
- R2: A time quantum lasts P clock cycles, where P is `presc_val`; a value of 0 is treated as P = 1. `tq_tick` is high for exactly one clock, on the first clock of every quantum.
- R3: A segment-1 code n gives n+1 quanta and a segment-2 code m gives m+1 quanta. One bit lasts (1 + (n+1) + (m+1)) × P clocks, measured between consecutive `bit_start` pulses, and carries that many `tq_tick` pulses.
- R4: Every bit begins with a synchronization segment of exactly one quantum. `bit_start` coincides with a `tq_tick`, and the next `tq_tick` comes P clocks later, where segment 1 begins.
- R5: `sample_pulse` is high for exactly one clock per bit: the last clock of the last quantum of segment 1, (n+2) × P − 1 clocks after the `bit_start` clock. It never coincides with `bit_start`.
- R6: `cfg_err` is high one clock after a segment-1 code of 0, 1 or 2 is presented, and low one clock after any code from 3 to 15 is presented, whatever the state of `enable`.
- R7: One clock after `enable` is sampled low, all three strobes are low and the counters are back at the start of the synchronization segment. On the first clock after `enable` is sampled high again, `bit_start` and `tq_tick` are high.
- R8: A change of `presc_val` or the segment codes in the middle of a bit leaves that bit's length and sample point unchanged. The new values apply from the next `bit_start` onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the timing chain; low holds it at the start of the sync segment |
| presc_val | input | PRESC_W | Clock cycles per time quantum (0 acts as 1) |
| tseg1_code | input | 4 | Segment-1 length code, quanta = code + 1 |
| tseg2_code | input | 3 | Segment-2 length code, quanta = code + 1 |
| tq_tick | output | 1 | One-clock pulse at the first clock of each quantum |
| sample_pulse | output | 1 | One-clock pulse at the last clock of segment 1 |
| bit_start | output | 1 | One-clock pulse at the first clock of the sync segment |
| cfg_err | output | 1 | Segment-1 code is below the valid range |

## Verification
The assertions check, on every cycle, the properties that do not depend on arithmetic over a whole bit. The quantum and bit counters stay inside their configured ranges, and the effective prescaler is never zero. Every `bit_start` lands on a quantum tick, and a sample pulse is never a bit start and is always followed by a tick. A disabled block emits no strobes. Bit lengths, sample-point offsets and tick counts across several prescaler and segment settings can only be shown by the bench's scenarios. The same goes for the full table of segment-1 codes and their error flag, the deferred take-up of a mid-bit configuration change, and the restart after a disable.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

  localparam int TSEG1_W    = 4;
  localparam int TSEG2_W    = 3;
  localparam int MAX_BIT_TQ = 1 + (1 << TSEG1_W) + (1 << TSEG2_W);
  localparam int QCNT_W     = $clog2(MAX_BIT_TQ + 1);

  typedef logic [QCNT_W-1:0] tq_count_t;

  typedef struct packed {
    logic [TSEG1_W-1:0] seg1_code;
    logic [TSEG2_W-1:0] seg2_code;
  } seg_cfg_t;

  // Length codes are value-plus-one encoded
  function automatic tq_count_t seg1_quanta(input logic [TSEG1_W-1:0] code);
    return tq_count_t'(code) + tq_count_t'(1);
  endfunction

  function automatic tq_count_t seg2_quanta(input logic [TSEG2_W-1:0] code);
    return tq_count_t'(code) + tq_count_t'(1);
  endfunction

  // Sync quantum plus both segments
  function automatic tq_count_t bit_quanta(input seg_cfg_t cfg);
    return tq_count_t'(1) + seg1_quanta(cfg.seg1_code) + seg2_quanta(cfg.seg2_code);
  endfunction

endpackage

// File: rtl/can_bt_cfg_reg.sv
module can_bt_cfg_reg
  import can_bt_pkg::*;
#(
  parameter int PRESC_W     = 8,
  parameter int MIN_T1_CODE = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic [PRESC_W-1:0]    presc_in,
  input  seg_cfg_t              seg_in,
  output logic [PRESC_W-1:0]    period_q,
  output tq_count_t             t1_q,
  output tq_count_t             nbit_q,
  output logic                  cfg_err_q
);

  localparam logic [PRESC_W-1:0] PERIOD_ONE = PRESC_W'(1);

  logic [PRESC_W-1:0] period_eff;

  always_comb begin
    period_eff = (presc_in == '0) ? PERIOD_ONE : presc_in;
  end

  // Shadow copy, refreshed only at bit boundaries or while idle
  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= PERIOD_ONE;
      t1_q     <= tq_count_t'(1);
      nbit_q   <= tq_count_t'(3);
    end else if (load) begin
      period_q <= period_eff;
      t1_q     <= seg1_quanta(seg_in.seg1_code);
      nbit_q   <= bit_quanta(seg_in);
    end
  end

  // Error flag tracks the programmed code regardless of enable
  always_ff @(posedge clk) begin
    if (rst) cfg_err_q <= 1'b0;
    else     cfg_err_q <= (int'(seg_in.seg1_code) < MIN_T1_CODE);
  end

  AST_PERIOD_NONZERO: assert property (@(posedge clk) disable iff (rst)
    period_q != '0); // R2

  AST_SAMPLE_INSIDE_BIT: assert property (@(posedge clk) disable iff (rst)
    t1_q < nbit_q); // R5

endmodule

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler #(
  parameter int PRESC_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               adv,
  input  logic [PRESC_W-1:0] period,
  output logic [PRESC_W-1:0] pcnt_q,
  output logic [PRESC_W-1:0] pcnt_nxt,
  output logic               q_end
);

  localparam logic [PRESC_W-1:0] ONE = PRESC_W'(1);

  always_comb begin
    q_end = adv && (pcnt_q == (period - ONE));
    if (!adv || q_end) pcnt_nxt = '0;
    else               pcnt_nxt = pcnt_q + ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) pcnt_q <= '0;
    else     pcnt_q <= pcnt_nxt;
  end

  AST_PCNT_IN_QUANTUM: assert property (@(posedge clk) disable iff (rst)
    pcnt_q < period); // R2

  AST_IDLE_PCNT_HOME: assert property (@(posedge clk) disable iff (rst)
    !adv |=> pcnt_q == '0); // R7

endmodule

// File: rtl/can_bt_seg_ctr.sv
module can_bt_seg_ctr
  import can_bt_pkg::*;
#(
  parameter int PRESC_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               adv,
  input  logic               q_end,
  input  logic [PRESC_W-1:0] pcnt_nxt,
  input  logic [PRESC_W-1:0] period,
  input  tq_count_t          t1,
  input  tq_count_t          nbit,
  output logic               load,
  output logic               tq_tick,
  output logic               sample_pulse,
  output logic               bit_start
);

  localparam logic [PRESC_W-1:0] PONE = PRESC_W'(1);
  localparam tq_count_t          QONE = tq_count_t'(1);

  tq_count_t qcnt_q, qcnt_nxt;
  logic      qlast, wrap;
  logic      tick_nxt, bs_nxt, smp_nxt;

  always_comb begin
    qlast = (qcnt_q == (nbit - QONE));
    wrap  = q_end && qlast;
    if (!adv)       qcnt_nxt = '0;
    else if (q_end) qcnt_nxt = qlast ? '0 : qcnt_q + QONE;
    else            qcnt_nxt = qcnt_q;
    load = !adv || wrap;
  end

  // Strobes decoded from next state so they line up with the counters
  always_comb begin
    tick_nxt = en && (pcnt_nxt == '0);
    bs_nxt   = tick_nxt && (qcnt_nxt == '0);
    smp_nxt  = en && (qcnt_nxt == t1) && (pcnt_nxt == (period - PONE));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      qcnt_q       <= '0;
      tq_tick      <= 1'b0;
      bit_start    <= 1'b0;
      sample_pulse <= 1'b0;
    end else begin
      qcnt_q       <= qcnt_nxt;
      tq_tick      <= tick_nxt;
      bit_start    <= bs_nxt;
      sample_pulse <= smp_nxt;
    end
  end

  AST_QCNT_IN_BIT: assert property (@(posedge clk) disable iff (rst)
    qcnt_q < nbit); // R3

  AST_BIT_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    bit_start |-> tq_tick); // R4

  AST_SAMPLE_NOT_SYNC: assert property (@(posedge clk) disable iff (rst)
    sample_pulse |-> !bit_start); // R5

  AST_SAMPLE_THEN_TICK: assert property (@(posedge clk) disable iff (rst)
    sample_pulse && en |=> tq_tick); // R5

endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
  import can_bt_pkg::*;
#(
  parameter int PRESC_W     = 8,
  parameter int MIN_T1_CODE = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 enable,
  input  logic [PRESC_W-1:0]   presc_val,
  input  logic [TSEG1_W-1:0]   tseg1_code,
  input  logic [TSEG2_W-1:0]   tseg2_code,
  output logic                 tq_tick,
  output logic                 sample_pulse,
  output logic                 bit_start,
  output logic                 cfg_err
);

  logic               run_q;
  logic               adv;
  logic               load;
  logic               q_end;
  logic [PRESC_W-1:0] pcnt_q, pcnt_nxt;
  logic [PRESC_W-1:0] period_q;
  tq_count_t          t1_q, nbit_q;
  seg_cfg_t           seg_in;

  // First enabled clock is spent as the first clock of the sync segment
  always_ff @(posedge clk) begin
    if (rst) run_q <= 1'b0;
    else     run_q <= enable;
  end

  always_comb begin
    adv              = enable && run_q;
    seg_in.seg1_code = tseg1_code;
    seg_in.seg2_code = tseg2_code;
  end

  can_bt_cfg_reg #(
    .PRESC_W     (PRESC_W),
    .MIN_T1_CODE (MIN_T1_CODE)
  ) cfg_i (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .presc_in  (presc_val),
    .seg_in    (seg_in),
    .period_q  (period_q),
    .t1_q      (t1_q),
    .nbit_q    (nbit_q),
    .cfg_err_q (cfg_err)
  );

  can_bt_prescaler #(
    .PRESC_W (PRESC_W)
  ) presc_i (
    .clk      (clk),
    .rst      (rst),
    .adv      (adv),
    .period   (period_q),
    .pcnt_q   (pcnt_q),
    .pcnt_nxt (pcnt_nxt),
    .q_end    (q_end)
  );

  can_bt_seg_ctr #(
    .PRESC_W (PRESC_W)
  ) seg_i (
    .clk          (clk),
    .rst          (rst),
    .en           (enable),
    .adv          (adv),
    .q_end        (q_end),
    .pcnt_nxt     (pcnt_nxt),
    .period       (period_q),
    .t1           (t1_q),
    .nbit         (nbit_q),
    .load         (load),
    .tq_tick      (tq_tick),
    .sample_pulse (sample_pulse),
    .bit_start    (bit_start)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !tq_tick && !sample_pulse && !bit_start); // R7

  AST_RESTART_SYNC: assert property (@(posedge clk) disable iff (rst)
    enable && !run_q |=> bit_start); // R7

endmodule

// File: tb/can_bit_timer_tb_top.sv
`timescale 1ns/1ps
module can_bit_timer_tb_top;

  localparam int PW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          enable;
  logic [PW-1:0] presc_val;
  logic [3:0]    tseg1_code;
  logic [2:0]    tseg2_code;
  logic          tq_tick, sample_pulse, bit_start, cfg_err;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  can_bit_timer #(.PRESC_W(PW)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .enable       (enable),
    .presc_val    (presc_val),
    .tseg1_code   (tseg1_code),
    .tseg2_code   (tseg2_code),
    .tq_tick      (tq_tick),
    .sample_pulse (sample_pulse),
    .bit_start    (bit_start),
    .cfg_err      (cfg_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int eff_p(input int p);
    return (p == 0) ? 1 : p;
  endfunction

  task automatic setup(input int p, input int c1, input int c2);
    @(negedge clk);
    enable     = 1'b0;
    presc_val  = PW'(p);
    tseg1_code = 4'(c1);
    tseg2_code = 3'(c2);
    repeat (2) @(negedge clk);
  endtask

  task automatic start_run(input string tag);
    enable = 1'b1;
    @(negedge clk);
    chk(bit_start == 1'b1, {tag, " R7 bit_start on restart"}, int'(bit_start), 1);
    chk(tq_tick == 1'b1, {tag, " R4 tick with bit_start"}, int'(tq_tick), 1);
  endtask

  // Starts at a negedge where bit_start is high; returns at the next one
  task automatic measure_bit(output int len, output int samp_off, output int nsamp,
                             output int nticks, output int tick2_off);
    int guard = 0;
    while (!bit_start && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    len = 0; samp_off = -1; nsamp = 0; nticks = 0; tick2_off = -1;
    do begin
      if (tq_tick) begin
        nticks++;
        if (nticks == 2) tick2_off = len;
      end
      if (sample_pulse) begin
        nsamp++;
        samp_off = len;
      end
      @(negedge clk);
      len++;
    end while (!bit_start && len < 5000);
  endtask

  task automatic check_bit(input int p, input int c1, input int c2, input string tag);
    int len, so, ns, nt, t2;
    int pp = eff_p(p);
    int nq = c1 + c2 + 3;
    measure_bit(len, so, ns, nt, t2);
    chk(len == nq * pp, {tag, " R3 bit length"}, len, nq * pp);
    chk(nt == nq, {tag, " R2 ticks per bit"}, nt, nq);
    chk(t2 == pp, {tag, " R4 sync lasts one quantum"}, t2, pp);
    chk(ns == 1, {tag, " R5 one sample per bit"}, ns, 1);
    chk(so == (c1 + 2) * pp - 1, {tag, " R5 sample offset"}, so, (c1 + 2) * pp - 1);
  endtask

  task automatic test_reset();
    rst = 1'b1; enable = 1'b1; presc_val = PW'(2);
    tseg1_code = 4'd3; tseg2_code = 3'd2;
    repeat (3) @(negedge clk);
    chk(!tq_tick && !sample_pulse && !bit_start, "R1 strobes low in reset",
        int'({tq_tick, sample_pulse, bit_start}), 0);
    chk(cfg_err == 1'b0, "R1 cfg_err low in reset", int'(cfg_err), 0);
    enable = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(!tq_tick && !sample_pulse && !bit_start, "R1 strobes low after reset",
        int'({tq_tick, sample_pulse, bit_start}), 0);
  endtask

  task automatic test_shape(input int p, input int c1, input int c2, input string tag);
    setup(p, c1, c2);
    start_run(tag);
    check_bit(p, c1, c2, tag);
    check_bit(p, c1, c2, tag);
  endtask

  task automatic test_cfg_err();
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      tseg1_code = 4'(c);
      @(negedge clk);
      chk(cfg_err == (c < 3), "R6 cfg_err per code", int'(cfg_err), int'(c < 3));
    end
    enable = 1'b1;
    tseg1_code = 4'd1;
    repeat (3) @(negedge clk);
    chk(cfg_err == 1'b1, "R6 cfg_err while enabled", int'(cfg_err), 1);
    tseg1_code = 4'd3;
    @(negedge clk);
    chk(cfg_err == 1'b0, "R6 cfg_err clears", int'(cfg_err), 0);
  endtask

  task automatic test_midbit_change();
    setup(2, 3, 2);
    start_run("midbit");
    presc_val  = PW'(3);
    tseg1_code = 4'd5;
    tseg2_code = 3'd3;
    check_bit(2, 3, 2, "R8 old cfg current bit");
    check_bit(3, 5, 3, "R8 new cfg next bit");
  endtask

  task automatic test_disable();
    setup(2, 3, 2);
    start_run("disable");
    repeat (5) @(negedge clk);
    enable = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!tq_tick && !sample_pulse && !bit_start, "R7 quiet while disabled",
          int'({tq_tick, sample_pulse, bit_start}), 0);
    end
    start_run("reenable");
    check_bit(2, 3, 2, "R7 full bit after restart");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    test_reset();
    test_shape(2, 3, 2, "basic");
    test_shape(1, 15, 7, "presc1");
    test_shape(0, 4, 0, "presc0");
    test_shape(5, 6, 1, "presc5");
    test_cfg_err();
    test_midbit_change();
    test_disable();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule